// File: doc/BRIEF.md
# Programmable Bus Clock Ratio Generator

This block runs on the fast core clock and produces two slower bus timing strobes. `h_stb` marks the start of each high-speed bus clock period and `p_stb` marks the start of each peripheral bus clock period. Each strobe lasts one core cycle. Two square waves, `h_clk` and `p_clk`, follow the same periods so the bus clocks can be observed. The divide ratios come from a 5-bit control word. The H divider can be 1, 2, 3, 4, 6 or 8, and the P clock runs at either the H rate or half of it. This gives core:H:P ratios from 1:1:1 up to 1:8:16.

Software writes the control word through a synchronous write strobe. A new word does not take effect at once. It is held as pending until a latency has passed, and that latency depends on the current and new ratios. The switch then happens on an H period boundary. Every H period is therefore emitted at full length, and the P clock is realigned to the first H period of the new ratio.

Top module: `clk_ratio_gen`

## Requirements
- R1: After a synchronous reset the ratio is 1:1:1. From the first clock edge after reset, `h_stb`, `p_stb`, `h_clk` and `p_clk` are all high in every core cycle.
- R2: Bits [2:1] of the control word select the H divider. The value 0 selects 1, 1 selects 2, 2 selects 4 and 3 selects 3. While a ratio is active, `h_stb` pulses exactly once every divider cycles.
- R3: Bit 4 turns the divide-by-3 into a divide-by-6, but only when bits [2:1] equal 3. Bit 3 turns the divide-by-4 into a divide-by-8, but only when bits [2:1] equal 2. In every other combination these two bits have no effect.
- R4: Bit 0 selects P = H (0) or P = H/2 (1). `p_stb` is only ever high in a cycle where `h_stb` is high.
- R5: In the normal case, a written word becomes active at the first H boundary that falls at least ceil(1.5 × old H divider) core cycles after the write edge. The first H strobe of the new ratio follows that boundary.
- R6: The fast case applies when the active ratio is 1:1:1 and the new word selects 1:1:2, 1:2:2 or 1:2:4. The minimum latency is then one old H period, which is one core cycle.
- R7: A switch happens only at an H boundary. The last H period of the old ratio and the first H period of the new ratio both have full length.
- R8: A write replaces any pending word, and the latency restarts from that write. A write edge never changes the active ratio.
- R9: `h_clk` is high for the first ceil(div/2) core cycles of each H period and rises with `h_stb`. `p_clk` is high for the first H period of each P period when P = H/2, and otherwise equals `h_clk`.
- R10: On a switch, the P sequence restarts, so `p_stb` is high together with the first H strobe of the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 5 | Control word: [4] div-6 select, [3] div-8 select, [2:1] H select, [0] P half |
| h_stb | output | 1 | One-cycle strobe at each H period start |
| p_stb | output | 1 | One-cycle strobe at each P period start |
| h_clk | output | 1 | H square wave for observation |
| p_clk | output | 1 | P square wave for observation |

## Verification
The bench sweeps all 32 control words twice. In the first pass each word is written after a return to 1:1:1, which exercises the fast path from the default ratio and the normal path back from every ratio. In the second pass the words are written one after another, so many different old dividers are crossed. For each change, the bench finds the switch boundary from the old period and the latency, then checks the strobe and square-wave spacing for two full P periods. Unused select-bit combinations must produce the plain divider, and this separates correct decoding from leakage of the select bits. A final case writes twice within one long latency window. This shows whether the first word is discarded and whether the wait restarts from the second write.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int WORD_W = 5;

  typedef struct packed {
    logic       h3_half;
    logic       h4_half;
    logic [1:0] h_sel;
    logic       p_half;
  } ratio_t;

  function automatic int h_div_of(ratio_t r);
    case (r.h_sel)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return r.h4_half ? 8 : 4;
      default: return r.h3_half ? 6 : 3;
    endcase
  endfunction

  function automatic logic fast_path(ratio_t cur, ratio_t nxt);
    int dc, dn;
    dc = h_div_of(cur);
    dn = h_div_of(nxt);
    return (dc == 1) && !cur.p_half && (((dn == 1) && nxt.p_half) || (dn == 2));
  endfunction

  function automatic int latency_of(ratio_t cur, ratio_t nxt);
    int dc;
    dc = h_div_of(cur);
    return fast_path(cur, nxt) ? dc : (3 * dc + 1) / 2;
  endfunction
endpackage

// File: rtl/clk_ratio_ctl.sv
module clk_ratio_ctl
  import clk_ratio_pkg::*;
#(
  parameter int LAT_W = 5
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  ratio_t wr_word,
  input  logic   boundary,
  output ratio_t act_q,
  output ratio_t act_d,
  output logic   apply
);
  ratio_t             pend_q;
  logic               pend_vld;
  logic [LAT_W-1:0]   wait_q;

  assign apply = pend_vld && (wait_q == '0) && boundary && !wr_en;
  assign act_d = apply ? pend_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= '0;
      pend_q   <= '0;
      pend_vld <= 1'b0;
      wait_q   <= '0;
    end else if (wr_en) begin
      pend_q   <= wr_word;
      pend_vld <= 1'b1;
      wait_q   <= LAT_W'(latency_of(act_q, wr_word) - 1);
    end else begin
      if (wait_q != '0) wait_q <= wait_q - LAT_W'(1);
      if (apply) begin
        act_q    <= pend_q;
        pend_vld <= 1'b0;
      end
    end
  end

  // R8: a write edge leaves the active ratio as it was
  assert_write_holds_ratio_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> $stable(act_q));
endmodule

// File: rtl/clk_ratio_hcnt.sv
module clk_ratio_hcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] act_div,
  input  logic [CNT_W-1:0] next_div,
  output logic             boundary,
  output logic             hclk_d,
  output logic             h_stb,
  output logic             h_clk
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] hi_len;

  assign boundary = (cnt_q == act_div - CNT_W'(1));
  assign cnt_d    = boundary ? '0 : cnt_q + CNT_W'(1);
  assign hi_len   = (next_div + CNT_W'(1)) >> 1;
  assign hclk_d   = (cnt_d < hi_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      h_stb <= 1'b0;
      h_clk <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      h_stb <= boundary;
      h_clk <= hclk_d;
    end
  end

  // R7: the phase counter never passes the active divider
  assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < act_div);
  // R9: the H square wave is high when the strobe fires
  assert_hstb_on_high_R9: assert property (@(posedge clk) disable iff (rst)
    h_stb |-> h_clk);
endmodule

// File: rtl/clk_ratio_pgen.sv
module clk_ratio_pgen (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic apply,
  input  logic p_half_d,
  input  logic hclk_d,
  output logic p_stb,
  output logic p_clk
);
  logic ph_q;
  logic ph_d;

  always_comb begin
    if (apply)         ph_d = p_half_d;
    else if (boundary) ph_d = p_half_d & ~ph_q;
    else               ph_d = ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 1'b0;
      p_stb <= 1'b0;
      p_clk <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      p_stb <= boundary & (apply | ~ph_q);
      p_clk <= p_half_d ? ph_d : hclk_d;
    end
  end

  // R9: the P square wave is high when the P strobe fires
  assert_pstb_on_high_R9: assert property (@(posedge clk) disable iff (rst)
    p_stb |-> p_clk);
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LAT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              h_stb,
  output logic              p_stb,
  output logic              h_clk,
  output logic              p_clk
);
  ratio_t           act_q;
  ratio_t           act_d;
  logic             apply;
  logic             boundary;
  logic             hclk_d;
  logic [CNT_W-1:0] act_div;
  logic [CNT_W-1:0] next_div;

  assign act_div  = CNT_W'(h_div_of(act_q));
  assign next_div = CNT_W'(h_div_of(act_d));

  clk_ratio_ctl #(.LAT_W(LAT_W)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(ratio_t'(wr_data)),
    .boundary(boundary), .act_q(act_q), .act_d(act_d), .apply(apply)
  );

  clk_ratio_hcnt #(.CNT_W(CNT_W)) u_hcnt (
    .clk(clk), .rst(rst), .act_div(act_div), .next_div(next_div),
    .boundary(boundary), .hclk_d(hclk_d), .h_stb(h_stb), .h_clk(h_clk)
  );

  clk_ratio_pgen u_pgen (
    .clk(clk), .rst(rst), .boundary(boundary), .apply(apply),
    .p_half_d(act_d.p_half), .hclk_d(hclk_d), .p_stb(p_stb), .p_clk(p_clk)
  );

  // R4: a P period always starts on an H period start
  assert_p_on_h_R4: assert property (@(posedge clk) disable iff (rst)
    p_stb |-> h_stb);
  // R10: a ratio switch restarts the P sequence at the next edge
  assert_switch_p_align_R10: assert property (@(posedge clk) disable iff (rst)
    apply |=> p_stb);
endmodule

// File: tb/clk_ratio_gen_bench.sv
module clk_ratio_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic       h_stb, p_stb, h_clk, p_clk;
  int total = 0;
  int bad = 0;
  logic [4:0] cur = '0;

  always #10 clk = ~clk;

  clk_ratio_gen u_clk_ratio_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .h_stb(h_stb), .p_stb(p_stb), .h_clk(h_clk), .p_clk(p_clk)
  );

  function automatic int e_div(logic [4:0] w);
    case (w[2:1])
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return w[3] ? 8 : 4;
      default: return w[4] ? 6 : 3;
    endcase
  endfunction

  function automatic bit e_fast(logic [4:0] o, logic [4:0] n);
    return e_div(o) == 1 && !o[0] && ((e_div(n) == 1 && n[0]) || e_div(n) == 2);
  endfunction

  function automatic int e_lat(logic [4:0] o, logic [4:0] n);
    return e_fast(o, n) ? e_div(o) : (3 * e_div(o) + 1) / 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (word %0d)", req, act, exp, cur);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_word(logic [4:0] w);
    wr_en = 1'b1;
    wr_data = w;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_change(logic [4:0] nw);
    int lat, dold, dn, pm, prev, s;
    string rq_t, rq_d;
    lat  = e_lat(cur, nw);
    dold = e_div(cur);
    dn   = e_div(nw);
    pm   = nw[0] ? 2 : 1;
    rq_t = e_fast(cur, nw) ? "R6" : "R5";
    rq_d = ((nw[2:1] == 2'd3 && nw[4]) || (nw[2:1] == 2'd2 && nw[3])) ? "R3" : "R2";
    write_word(nw);
    prev = -1;
    s = -1;
    for (int t = 1; t <= lat + dold + 1; t++) begin
      step();
      if (p_stb) chk(h_stb, "R4", h_stb, 1);
      if (h_stb) begin
        if (t >= lat) begin
          s = t;
          break;
        end
        prev = t;
      end
    end
    chk(s >= lat && s < lat + dold, rq_t, s, lat);
    if (prev >= 0) chk(s - prev == dold, "R7", s - prev, dold);
    cur = nw;
    chk(p_stb == 1'b1, "R10", p_stb, 1);
    chk(h_clk == 1'b1, "R9", h_clk, 1);
    chk(p_clk == 1'b1, "R9", p_clk, 1);
    for (int t = 1; t <= 2 * dn * pm; t++) begin
      step();
      chk(h_stb == (t % dn == 0), rq_d, h_stb, t % dn == 0);
      chk(p_stb == (t % (dn * pm) == 0), "R4", p_stb, t % (dn * pm) == 0);
      chk(h_clk == ((t % dn) < (dn + 1) / 2), "R9", h_clk, (t % dn) < (dn + 1) / 2);
      if (pm == 2)
        chk(p_clk == ((t % (2 * dn)) < dn), "R9", p_clk, (t % (2 * dn)) < dn);
      else
        chk(p_clk == h_clk, "R9", p_clk, h_clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(h_stb && p_stb && h_clk && p_clk, "R1",
          {h_stb, p_stb, h_clk, p_clk}, 4'hf);
    end
    for (int w = 0; w < 32; w++) begin
      do_change(5'd0);
      do_change(5'(w));
    end
    for (int w = 0; w < 32; w++) do_change(5'(w));
    // R8: a second write inside a long wait drops the first and restarts the wait
    do_change(5'b01100);
    write_word(5'b00110);
    for (int i = 0; i < 4; i++) begin
      step();
      if (p_stb) chk(h_stb, "R4", h_stb, 1);
    end
    do_change(5'b00001);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule